// File: doc/BRIEF.md
# In-Application Flash Programming Controller

This block lets application code change its own nonvolatile storage. Software loads a target byte address, a data byte and an operation code through a small byte-wide register interface. It then writes a two-value key to a key register. If the key is accepted, the controller runs one of three operations on a behavioural flash array: read one byte, program one byte, or erase a whole 512-byte page. While the operation runs, the controller holds a stall output that freezes the processor outright. When the stall drops, the processor carries on with the instruction after the one that started the operation.

Only one address window may be modified this way. A key sequence that targets an address outside that window is discarded without a trace. It causes no stall and no memory change, and the done flag stays clear. During the stall, interrupt requests are masked at the block's interrupt output. When the stall ends, the requests that are still asserted pass through at once. A level request that went away during the stall is never seen.

A second read path, the code port, returns stored bytes directly. It is used while the processor runs and has one cycle of latency.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, the data register reads 0xFF. The address, mode and status registers read 0x00. `cpu_stall` and `irq_out` are 0.
- R2: The data register at register address 0xE2 reads back the last value written to it.
- R3: An operation starts only if 0x46 is written to the key register (0xE6) and the very next register write is 0xB9 to the same register. Any other write in between, or a wrong value, starts nothing.
- R4: If the target address lies outside [REGION_LO, REGION_HI] (default 0x400..0x7FF), an accepted key is ignored: no stall, no done flag, no memory change.
- R5: The mode register (0xE5) bits [1:0] select the operation: 01 read, 10 byte program, 11 page erase. A value of 00 starts nothing.
- R6: A read holds `cpu_stall` for READ_CYC cycles (default 2). It then leaves the addressed byte in the data register.
- R7: A byte program holds `cpu_stall` for WRITE_CYC cycles (default 16). The stored byte becomes the old byte ANDed with the data register.
- R8: A page erase holds `cpu_stall` for ERASE_CYC cycles (default 64). Every byte of the 512-byte page containing the address becomes 0xFF. Other pages keep their contents.
- R9: Status register 0xE7 bit 0 is the done flag. It is set on the cycle `cpu_stall` falls and is cleared only by writing it with bit 0 = 1. Bit 1 mirrors `cpu_stall`.
- R10: While `cpu_stall` is high, `irq_out` is all zero. Otherwise `irq_out` equals `irq_req` of the previous cycle, so a request that drops during the stall is lost.
- R11: Register writes made while `cpu_stall` is high change no register.
- R12: `code_rdata` gives the stored byte at `code_addr` one cycle after the address is applied.
- R13: `cpu_stall` is high in the cycle right after the accepted 0xB9 key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's `reg_addr` |
| code_addr | input | ADDR_W | Direct read byte address |
| code_rdata | output | 8 | Direct read data, one cycle latency |
| irq_req | input | IRQ_N | Enabled interrupt request levels |
| irq_out | output | IRQ_N | Requests forwarded to the processor |
| cpu_stall | output | 1 | Processor freeze while an operation runs |

## Verification
A table of operations is run on the main function:
- programs that clear only some bits, to expose a plain overwrite;
- a second program to the same byte, to show that bits cannot be set back;
- erases on two pages, each followed by reads of the other page;
- targets just below and at the edges of the window, to separate an inclusive region check from an off-by-one check.

Stall lengths are counted cycle by cycle for each operation code, so a wrong duration or a mode decode mix-up shows directly. Directed cases cover the following:
- broken key sequences;
- register writes during a stall;
- one interrupt level that is held through a stall and another that drops during it.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_ERASE = 2'b11
  } fpc_op_e;

  localparam logic [7:0] RA_DATA  = 8'hE2;
  localparam logic [7:0] RA_ADRL  = 8'hE3;
  localparam logic [7:0] RA_ADRH  = 8'hE4;
  localparam logic [7:0] RA_MODE  = 8'hE5;
  localparam logic [7:0] RA_KEY   = 8'hE6;
  localparam logic [7:0] RA_STAT  = 8'hE7;

  localparam logic [7:0] KEY_FIRST  = 8'h46;
  localparam logic [7:0] KEY_SECOND = 8'hB9;
endpackage

// File: rtl/fpc_flash_model.sv
module fpc_flash_model #(
  parameter int unsigned WORDS  = 256,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cells [WORDS];

  // blank array at configuration time
  initial begin
    for (int i = 0; i < WORDS; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  localparam int unsigned HI_W  = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              stall,
  input  logic              done_set,
  input  logic              rd_load,
  input  logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] op_addr,
  output fpc_op_e           op_mode,
  output logic [7:0]        op_data,
  output logic              kick
);
  logic [7:0]        data_q;
  logic [ADDR_W-1:0] adr_q;
  fpc_op_e           mode_q;
  logic              armed_q;
  logic              done_q;
  logic              wr_ok;
  logic [15:0]       adr_ext;

  assign wr_ok   = we && !stall;
  assign kick    = wr_ok && (addr == RA_KEY) && (wdata == KEY_SECOND) && armed_q;
  assign op_addr = adr_q;
  assign op_mode = mode_q;
  assign op_data = data_q;
  assign adr_ext = 16'(adr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= 8'hFF;
      adr_q   <= '0;
      mode_q  <= OP_NONE;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr_ok) begin
        armed_q <= (addr == RA_KEY) && (wdata == KEY_FIRST);
        unique case (addr)
          RA_DATA: data_q <= wdata;
          RA_ADRL: adr_q[7:0] <= wdata;
          RA_ADRH: adr_q[ADDR_W-1:8] <= wdata[HI_W-1:0];
          RA_MODE: mode_q <= fpc_op_e'(wdata[1:0]);
          default: ;
        endcase
      end
      if (rd_load) data_q <= rd_byte;
      if (done_set) done_q <= 1'b1;
      else if (wr_ok && addr == RA_STAT && wdata[0]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        RA_DATA: rdata <= data_q;
        RA_ADRL: rdata <= adr_ext[7:0];
        RA_ADRH: rdata <= adr_ext[15:8];
        RA_MODE: rdata <= {6'b0, mode_q};
        RA_STAT: rdata <= {6'b0, stall, done_q};
        default: rdata <= '0;
      endcase
    end
  end

  // R9: done is set when the stall drops
  assert_done_on_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> done_q);
  // R11: configuration frozen while stalled
  assert_frozen_cfg_R11: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(mode_q) && $stable(adr_q));
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned LANES      = 8,
  parameter int unsigned PAGE_BYTES = 512,
  parameter logic [ADDR_W-1:0] REGION_LO = 11'h400,
  parameter logic [ADDR_W-1:0] REGION_HI = 11'h7FF,
  parameter int unsigned ERASE_CYC  = 64,
  parameter int unsigned WRITE_CYC  = 16,
  parameter int unsigned READ_CYC   = 2,
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned WORD_AW   = ADDR_W - LANE_W,
  localparam int unsigned WORD_W    = LANES * 8,
  localparam int unsigned PAGE_WORDS = PAGE_BYTES / LANES,
  localparam int unsigned PG_W      = $clog2(PAGE_WORDS),
  localparam int unsigned MAX_CYC   = (ERASE_CYC > WRITE_CYC) ?
                                      ((ERASE_CYC > READ_CYC) ? ERASE_CYC : READ_CYC) :
                                      ((WRITE_CYC > READ_CYC) ? WRITE_CYC : READ_CYC),
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               kick,
  input  fpc_op_e            mode,
  input  logic [ADDR_W-1:0]  op_addr,
  input  logic [7:0]         op_data,
  input  logic [ADDR_W-1:0]  code_addr,
  output logic [7:0]         code_rdata,
  output logic               busy,
  output logic               stall_next,
  output logic               done_set,
  output logic               rd_load,
  output logic [7:0]         rd_byte,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_waddr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic [WORD_AW-1:0] mem_raddr,
  input  logic [WORD_W-1:0]  mem_rdata
);
  function automatic logic [CNT_W-1:0] op_len(input fpc_op_e m);
    case (m)
      OP_READ:  return CNT_W'(READ_CYC);
      OP_WRITE: return CNT_W'(WRITE_CYC);
      OP_ERASE: return CNT_W'(ERASE_CYC);
      default:  return CNT_W'(1);
    endcase
  endfunction

  logic               busy_q;
  fpc_op_e            op_q;
  logic [WORD_AW-1:0] word_q;
  logic [LANE_W-1:0]  lane_q;
  logic [LANE_W-1:0]  code_lane_q;
  logic [7:0]         byte_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   len_q;
  logic [PG_W:0]      sweep_q;
  logic               in_region;
  logic               accept;
  logic               last;
  logic               sweeping;

  assign in_region = (op_addr >= REGION_LO) && (op_addr <= REGION_HI);
  assign accept    = kick && !busy_q && (mode != OP_NONE) && in_region;
  assign last      = busy_q && (cnt_q == '0);
  assign sweeping  = (sweep_q < (PG_W+1)'(PAGE_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      op_q    <= OP_NONE;
      word_q  <= '0;
      lane_q  <= '0;
      byte_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      sweep_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      op_q    <= mode;
      word_q  <= op_addr[ADDR_W-1:LANE_W];
      lane_q  <= op_addr[LANE_W-1:0];
      byte_q  <= op_data;
      cnt_q   <= op_len(mode) - CNT_W'(1);
      len_q   <= CNT_W'(1);
      sweep_q <= '0;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else begin
        cnt_q <= cnt_q - CNT_W'(1);
        len_q <= len_q + CNT_W'(1);
      end
      if (sweeping) sweep_q <= sweep_q + (PG_W+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_lane_q <= '0;
    else     code_lane_q <= code_addr[LANE_W-1:0];
  end

  // one read port shared: the processor is frozen while an operation runs
  assign mem_raddr  = busy_q ? word_q : code_addr[ADDR_W-1:LANE_W];
  assign code_rdata = mem_rdata[code_lane_q*8 +: 8];
  assign rd_byte    = mem_rdata[lane_q*8 +: 8];

  assign busy       = busy_q;
  assign stall_next = accept || (busy_q && !last);
  assign done_set   = last;
  assign rd_load    = last && (op_q == OP_READ);

  assign mem_we    = busy_q && (((op_q == OP_ERASE) && sweeping) ||
                                ((op_q == OP_WRITE) && last));
  assign mem_waddr = (op_q == OP_ERASE) ? {word_q[WORD_AW-1:PG_W], sweep_q[PG_W-1:0]}
                                        : word_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] old_b;
    assign old_b = mem_rdata[l*8 +: 8];
    assign mem_wdata[l*8 +: 8] = (op_q == OP_ERASE) ? 8'hFF :
                                 ((lane_q == LANE_W'(l)) ? (old_b & byte_q) : old_b);
  end

  // R6, R7, R8: busy window matches the selected operation's length
  assert_op_len_R8: assert property (@(posedge clk) disable iff (rst)
    last |-> (len_q == op_len(op_q)));
  // R4: a key aimed outside the window starts nothing
  assert_region_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (kick && !busy_q && !in_region) |=> !busy_q);
  // R5: an empty mode starts nothing
  assert_no_op_R5: assert property (@(posedge clk) disable iff (rst)
    (kick && !busy_q && mode == OP_NONE) |=> !busy_q);
endmodule

// File: rtl/fpc_irq_gate.sv
module fpc_irq_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [N-1:0] req,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (hold) q <= '0;
    else           q <= req;
  end

  // R10: outside a hold the request passes with one cycle delay
  assert_pass_through_R10: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (q == $past(req)));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned LANES      = 8,
  parameter int unsigned PAGE_BYTES = 512,
  parameter logic [ADDR_W-1:0] REGION_LO = 11'h400,
  parameter logic [ADDR_W-1:0] REGION_HI = 11'h7FF,
  parameter int unsigned ERASE_CYC  = 64,
  parameter int unsigned WRITE_CYC  = 16,
  parameter int unsigned READ_CYC   = 2,
  parameter int unsigned IRQ_N      = 4,
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned WORD_AW   = ADDR_W - LANE_W,
  localparam int unsigned WORD_W    = LANES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] code_addr,
  output logic [7:0]        code_rdata,
  input  logic [IRQ_N-1:0]  irq_req,
  output logic [IRQ_N-1:0]  irq_out,
  output logic              cpu_stall
);
  logic [ADDR_W-1:0]  op_addr;
  fpc_op_e            op_mode;
  logic [7:0]         op_data;
  logic               kick;
  logic               stall_next;
  logic               done_set;
  logic               rd_load;
  logic [7:0]         rd_byte;
  logic               mem_we;
  logic [WORD_AW-1:0] mem_waddr;
  logic [WORD_W-1:0]  mem_wdata;
  logic [WORD_AW-1:0] mem_raddr;
  logic [WORD_W-1:0]  mem_rdata;

  fpc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .stall(cpu_stall), .done_set(done_set),
    .rd_load(rd_load), .rd_byte(rd_byte), .op_addr(op_addr),
    .op_mode(op_mode), .op_data(op_data), .kick(kick)
  );

  fpc_seq #(
    .ADDR_W(ADDR_W), .LANES(LANES), .PAGE_BYTES(PAGE_BYTES),
    .REGION_LO(REGION_LO), .REGION_HI(REGION_HI),
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .kick(kick), .mode(op_mode), .op_addr(op_addr),
    .op_data(op_data), .code_addr(code_addr), .code_rdata(code_rdata),
    .busy(cpu_stall), .stall_next(stall_next), .done_set(done_set),
    .rd_load(rd_load), .rd_byte(rd_byte), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata)
  );

  fpc_flash_model #(.WORDS(1 << WORD_AW), .WORD_W(WORD_W)) u_flash (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  fpc_irq_gate #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .hold(stall_next), .req(irq_req), .q(irq_out)
  );

  // R10: nothing reaches the processor during a freeze
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> (irq_out == '0));
  // R13: accepted key raises the freeze on the next cycle
  assert_stall_follows_R13: assert property (@(posedge clk) disable iff (rst)
    (kick && !cpu_stall && op_mode != OP_NONE &&
     op_addr >= REGION_LO && op_addr <= REGION_HI) |=> cpu_stall);
endmodule

// File: tb/tb_flash_prog_ctrl.sv
`timescale 1ns/1ps
module tb_flash_prog_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [10:0] code_addr;
  logic [7:0]  code_rdata;
  logic [3:0]  irq_req;
  logic [3:0]  irq_out;
  logic        cpu_stall;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flash_prog_ctrl dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .code_addr(code_addr),
    .code_rdata(code_rdata), .irq_req(irq_req), .irq_out(irq_out),
    .cpu_stall(cpu_stall)
  );

  // {op[1:0], addr[15:0], data[7:0], check addr[15:0], expected byte[7:0], stall cycles[7:0]}
  localparam int NV = 12;
  localparam logic [57:0] VEC [NV] = '{
    {2'd2, 16'h0400, 8'h5A, 16'h0400, 8'h5A, 8'd16},
    {2'd2, 16'h0400, 8'hF0, 16'h0400, 8'h50, 8'd16},
    {2'd2, 16'h05FF, 8'h3C, 16'h05FF, 8'h3C, 8'd16},
    {2'd1, 16'h0400, 8'h00, 16'h0400, 8'h50, 8'd2},
    {2'd3, 16'h0401, 8'h00, 16'h05FF, 8'hFF, 8'd64},
    {2'd2, 16'h0600, 8'h81, 16'h0600, 8'h81, 8'd16},
    {2'd2, 16'h0200, 8'h00, 16'h0200, 8'hFF, 8'd0},
    {2'd1, 16'h0600, 8'h00, 16'h0600, 8'h81, 8'd2},
    {2'd3, 16'h07FF, 8'h00, 16'h0600, 8'hFF, 8'd64},
    {2'd2, 16'h07FF, 8'h7E, 16'h07FF, 8'h7E, 8'd16},
    {2'd0, 16'h07FF, 8'h00, 16'h07FF, 8'h7E, 8'd0},
    {2'd2, 16'h03FF, 8'h00, 16'h03FF, 8'hFF, 8'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic code_rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    code_addr = a[10:0];
    @(negedge clk);
    v = code_rdata;
  endtask

  task automatic wait_stall(output int n);
    n = 0;
    while (cpu_stall) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setup_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    reg_wr(8'hE3, a[7:0]);
    reg_wr(8'hE4, a[15:8]);
    reg_wr(8'hE2, d);
    reg_wr(8'hE5, {6'b0, op});
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] a,
                        input logic [7:0] d, output int cyc);
    setup_op(op, a, d);
    reg_wr(8'hE6, 8'h46);
    reg_wr(8'hE6, 8'hB9);
    wait_stall(cyc);
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cyc;
    rst = 1'b1; reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    code_addr = '0; irq_req = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 stall", {31'b0, cpu_stall}, 32'd0);
    check("R1 irq", {28'b0, irq_out}, 32'd0);
    reg_rd(8'hE2, v); check("R1 data", {24'b0, v}, 32'hFF);
    reg_rd(8'hE7, v); check("R1 status", {24'b0, v}, 32'h00);
    reg_rd(8'hE3, v); check("R1 addr", {24'b0, v}, 32'h00);
    reg_rd(8'hE5, v); check("R1 mode", {24'b0, v}, 32'h00);

    // R2 data register
    reg_wr(8'hE2, 8'hA5);
    reg_rd(8'hE2, v); check("R2 readback", {24'b0, v}, 32'hA5);

    // R3 broken key sequences
    setup_op(2'd2, 16'h0400, 8'h11);
    reg_wr(8'hE6, 8'h46);
    reg_wr(8'hE2, 8'h11);
    reg_wr(8'hE6, 8'hB9);
    wait_stall(cyc); check("R3 interrupted key", cyc, 0);
    reg_wr(8'hE6, 8'h47);
    reg_wr(8'hE6, 8'hB9);
    wait_stall(cyc); check("R3 wrong key", cyc, 0);
    code_rd(16'h0400, v); check("R3 memory intact", {24'b0, v}, 32'hFF);

    // table of operations: R4 R5 R6 R7 R8 R12
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] a, ca;
      logic [7:0]  d, ex, ec;
      string tag;
      {op, a, d, ca, ex, ec} = VEC[i];
      tag = (ec == 0) ? ((op == 2'd0) ? "R5" : "R4") :
            (op == 2'd1) ? "R6" : (op == 2'd2) ? "R7" : "R8";
      run_op(op, a, d, cyc);
      check({tag, " stall length"}, cyc, {24'b0, ec});
      reg_rd(8'hE7, v);
      check({"R9 done after ", tag}, {24'b0, v}, (ec == 0) ? 32'h0 : 32'h1);
      if (op == 2'd1 && ec != 0) begin
        reg_rd(8'hE2, v); check("R6 data loaded", {24'b0, v}, {24'b0, ex});
      end
      code_rd(ca, v); check({"R12 code read after ", tag}, {24'b0, v}, {24'b0, ex});
      reg_wr(8'hE7, 8'h01);
    end

    // R8 erase leaves another page alone
    run_op(2'd2, 16'h0410, 8'h11, cyc);
    run_op(2'd3, 16'h0700, 8'h00, cyc);
    check("R8 erase length", cyc, 64);
    code_rd(16'h0410, v); check("R8 other page kept", {24'b0, v}, 32'h11);

    // R9 write-one-to-clear
    reg_rd(8'hE7, v); check("R9 done set", {24'b0, v}, 32'h1);
    reg_wr(8'hE7, 8'h00);
    reg_rd(8'hE7, v); check("R9 zero keeps done", {24'b0, v}, 32'h1);
    reg_wr(8'hE7, 8'h01);
    reg_rd(8'hE7, v); check("R9 one clears done", {24'b0, v}, 32'h0);

    // R10 interrupt pass-through while idle
    @(negedge clk); irq_req = 4'b0011;
    @(negedge clk); check("R10 idle pass", {28'b0, irq_out}, 32'h3);

    // R11 R13 R10 writes and interrupts during a stall
    setup_op(2'd3, 16'h0600, 8'h77);
    reg_wr(8'hE6, 8'h46);
    reg_wr(8'hE6, 8'hB9);
    check("R13 stall next cycle", {31'b0, cpu_stall}, 32'd1);
    check("R10 masked in stall", {28'b0, irq_out}, 32'h0);
    reg_wr(8'hE2, 8'h33);
    reg_wr(8'hE5, 8'h01);
    irq_req = 4'b0001;
    @(negedge clk);
    check("R10 masked mid stall", {28'b0, irq_out}, 32'h0);
    wait_stall(cyc);
    check("R10 held level served, dropped lost", {28'b0, irq_out}, 32'h1);
    reg_rd(8'hE2, v); check("R11 data unchanged", {24'b0, v}, 32'h77);
    reg_rd(8'hE5, v); check("R11 mode unchanged", {24'b0, v}, 32'h3);
    irq_req = '0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule